// File: doc/BRIEF.md
# Saturating Clear-on-Read Filtered Cell Counter

This block keeps a statistics count of cells handled by a receive cell filter. Each cell is reported as a one-cycle valid strobe with two flags: one says the cell was dropped, the other says a copy went to the extraction buffer. A two-bit mode input selects which reports advance the count. The count saturates at all ones and never wraps.

Software reads the count as byte-wide registers. Reading byte address 0 returns the low byte. The same read latches the whole count into a snapshot and clears the live count. Reads of the higher byte addresses then return bytes of that snapshot, so a multi-byte read sees one consistent value. Each full read therefore gives the number of qualifying cells since the previous full read.

Top module: `cellstat_ctr`

## Requirements
- R1: While reset is high, and in the first cycle after it, the live count, the snapshot and `rd_data` are all zero.
- R2: The `cfg_mode` field selects which strobes qualify: 2'b00 counts cells with the drop flag set, 2'b01 counts cells with the copy flag set, 2'b10 counts cells with either flag set, and 2'b11 counts nothing. A strobe with `evt_vld` low never counts.
- R3: Once the live count equals all ones (0xFFFFFFFF at default width), further qualifying strobes leave it unchanged.
- R4: A read with `rd_addr` = 0 does three things. It returns bits 7:0 of the live count. It copies the full live count into the snapshot. It clears the live count. A later read at address k (1 to 3) returns snapshot bits 8k+7:8k, so address 3 returns bits 31:24.
- R5: If a qualifying strobe arrives in the same cycle as a clearing read, the live count becomes 1 rather than 0.
- R6: `rd_data` is updated on the clock edge at which `rd_en` is sampled high, so it is valid one cycle after the request. While `rd_en` is low it holds its value.
- R7: The count advances by at most one per clock. In mode 2'b10, a cell flagged as both dropped and copied adds exactly one.
- R8: Reads at addresses 1 to 3 neither clear nor change the live count, and they leave the snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Event qualification mode (see R2) |
| evt_vld | input | 1 | One-cycle cell report strobe |
| evt_drop | input | 1 | Reported cell was dropped |
| evt_copy | input | 1 | Reported cell was copied to the extraction buffer |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W (2) | Byte address, 0 = least significant |
| rd_data | output | BYTE_W (8) | Registered read data |

## Verification
Two actions can fall in the same cycle: a qualifying cell report and the clearing read at address 0. The bench drives both on one edge. It then expects the next full read to return 1, and it expects the returned low byte to be the count from before that event. A second collision is between saturation and further events. The bench checks this with a 16-bit instance that is driven past all ones and must read back 0xFFFF. It then checks that the following read returns zero.

// File: rtl/cellstat_pkg.sv
package cellstat_pkg;
  typedef enum logic [1:0] {
    MODE_DROP = 2'b00,
    MODE_COPY = 2'b01,
    MODE_ANY  = 2'b10,
    MODE_OFF  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/cellstat_qual.sv
module cellstat_qual
  import cellstat_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       vld,
  input  logic       drop,
  input  logic       copy,
  output logic       inc
);
  always_comb begin
    inc = 1'b0;
    if (vld) begin
      case (cnt_mode_e'(mode))
        MODE_DROP: inc = drop;
        MODE_COPY: inc = copy;
        MODE_ANY:  inc = drop | copy;
        default:   inc = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cellstat_satcnt.sv
module cellstat_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= inc ? ONE : '0;
    end else if (inc && cnt_q != MAXV) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/cellstat_rdport.sv
module cellstat_rdport #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              capture,
  input  logic [CNT_W-1:0]  live,
  output logic [CNT_W-1:0]  snap_q,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int NUM_BYTES = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] snap_bytes [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
    assign snap_bytes[g] = snap_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rd_data <= '0;
    end else begin
      if (capture) snap_q <= live;
      if (rd_en) begin
        if (capture) rd_data <= live[BYTE_W-1:0];
        else         rd_data <= snap_bytes[rd_addr];
      end
    end
  end
endmodule

// File: rtl/cellstat_ctr.sv
module cellstat_ctr #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = $clog2(CNT_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              evt_vld,
  input  logic              evt_drop,
  input  logic              evt_copy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic             cnt_inc;
  logic             cnt_clr;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] snap_q;

  assign cnt_clr = rd_en && (rd_addr == '0);

  cellstat_qual u_qual (
    .mode (cfg_mode),
    .vld  (evt_vld),
    .drop (evt_drop),
    .copy (evt_copy),
    .inc  (cnt_inc)
  );

  cellstat_satcnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (cnt_inc),
    .clr   (cnt_clr),
    .cnt_q (live_cnt)
  );

  cellstat_rdport #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .capture (cnt_clr),
    .live    (live_cnt),
    .snap_q  (snap_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/cellstat_ctr_chk.sv
module cellstat_ctr_chk #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic              evt_vld,
  input logic              evt_drop,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  snap_q
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic rd0;
  assign rd0 = rd_en && (rd_addr == '0);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (live_cnt == '0 && snap_q == '0 && rd_data == '0));

  p_mode_off_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b11 && !rd0) |=> $stable(live_cnt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == MAXV && !rd0) |=> live_cnt == MAXV);

  p_snap_take_r4: assert property (@(posedge clk) disable iff (rst)
    rd0 |=> snap_q == $past(live_cnt));

  p_clear_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (rd0 && !evt_vld) |=> live_cnt == '0);

  p_byte0_live_r4: assert property (@(posedge clk) disable iff (rst)
    rd0 |=> rd_data == $past(live_cnt[BYTE_W-1:0]));

  p_clear_evt_r5: assert property (@(posedge clk) disable iff (rst)
    (rd0 && evt_vld && evt_drop && cfg_mode == 2'b10) |=> live_cnt == ONE);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_step_one_r7: assert property (@(posedge clk) disable iff (rst)
    !rd0 |=> (live_cnt == $past(live_cnt) || live_cnt == $past(live_cnt) + ONE));

  p_snap_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !rd0 |=> $stable(snap_q));
endmodule

bind cellstat_ctr cellstat_ctr_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .evt_vld  (evt_vld),
  .evt_drop (evt_drop),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .live_cnt (live_cnt),
  .snap_q   (snap_q)
);

// File: tb/cellstat_ctr_tb_top.sv
module cellstat_ctr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic vld = 0, drp = 0, cpy = 0, rd = 0;
  logic [1:0] addr = 2'd0;
  logic [7:0] rdat;

  logic s_vld = 0, s_rd = 0;
  logic s_addr = 1'b0;
  logic [7:0] s_rdat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_cnt = 0;
  logic [31:0] exp_snap = 0;

  cellstat_ctr dut_i (
    .clk(clk), .rst(rst), .cfg_mode(mode), .evt_vld(vld), .evt_drop(drp),
    .evt_copy(cpy), .rd_en(rd), .rd_addr(addr), .rd_data(rdat)
  );

  cellstat_ctr #(.CNT_W(16)) sat_i (
    .clk(clk), .rst(rst), .cfg_mode(2'b00), .evt_vld(s_vld), .evt_drop(1'b1),
    .evt_copy(1'b0), .rd_en(s_rd), .rd_addr(s_addr), .rd_data(s_rdat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit qual(input logic [1:0] m, input bit v, input bit d, input bit c);
    if (!v) return 0;
    case (m)
      2'b00: return d;
      2'b01: return c;
      2'b10: return d | c;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit v, input bit d, input bit c, input bit r, input logic [1:0] a);
    bit q;
    @(negedge clk);
    vld = v; drp = d; cpy = c; rd = r; addr = a;
    q = qual(mode, v, d, c);
    @(posedge clk);
    #1;
    if (r && a == 2'd0) begin
      exp_snap = exp_cnt;
      exp_cnt = q ? 32'd1 : 32'd0;
    end else if (q && exp_cnt != 32'hFFFF_FFFF) begin
      exp_cnt = exp_cnt + 1;
    end
    vld = 0; drp = 0; cpy = 0; rd = 0; addr = 0;
  endtask

  task automatic rd_byte(input logic [1:0] a, input logic [7:0] e, input string tag);
    cyc(0, 0, 0, 1, a);
    chk(tag, {24'd0, rdat}, {24'd0, e});
  endtask

  task automatic read_all(input string tag);
    logic [31:0] e;
    e = exp_cnt;
    for (int k = 0; k < 4; k++) rd_byte(2'(k), e[8*k +: 8], tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data in reset", {24'd0, rdat}, 32'd0);
    @(negedge clk);
    rst = 0;
    @(posedge clk);
    #1;
    chk("R1 rd_data after reset", {24'd0, rdat}, 32'd0);
    read_all("R1 count after reset");

    // mode x flag sweep: R2 qualification, R7 single increment for both flags
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int k = 0; k < 8; k++) begin
        cyc(k[2], k[1], k[0], 0, 2'd0);
        cyc(k[2], k[1], k[0], 0, 2'd0);
        read_all("R2 R7 mode sweep");
      end
    end

    // multi-byte value and coherent snapshot: R4, R8
    mode = 2'b01;
    for (int i = 0; i < 773; i++) cyc(1, 0, 1, 0, 2'd0);
    chk("R4 model count", exp_cnt, 32'd773);
    rd_byte(2'd0, 8'h05, "R4 byte0");
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 2'd0);
    rd_byte(2'd1, 8'h03, "R4 R8 byte1 from snapshot");
    rd_byte(2'd2, 8'h00, "R4 byte2");
    rd_byte(2'd3, 8'h00, "R4 byte3");
    rd_byte(2'd1, 8'h03, "R8 snapshot kept");
    rd_byte(2'd0, 8'd10, "R8 live not cleared by upper reads");

    // R6 hold while idle
    cyc(1, 0, 1, 0, 2'd0);
    cyc(0, 0, 0, 0, 2'd0);
    chk("R6 rd_data held", {24'd0, rdat}, 32'd10);

    // R5 event coincides with clearing read
    mode = 2'b10;
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 2'd0);
    cyc(1, 1, 1, 1, 2'd0);
    chk("R5 read returns prior count", {24'd0, rdat}, 32'd5);
    rd_byte(2'd0, 8'd1, "R5 coinciding event kept");
    rd_byte(2'd0, 8'd0, "R4 cleared after read");

    // R3 saturation on 16-bit instance
    @(negedge clk);
    s_vld = 1;
    repeat (65540) @(posedge clk);
    @(negedge clk);
    s_vld = 0;
    s_rd = 1; s_addr = 1'b0;
    @(posedge clk); #1;
    chk("R3 sat low byte", {24'd0, s_rdat}, 32'hFF);
    @(negedge clk);
    s_addr = 1'b1;
    @(posedge clk); #1;
    chk("R3 sat high byte", {24'd0, s_rdat}, 32'hFF);
    @(negedge clk);
    s_addr = 1'b0;
    @(posedge clk); #1;
    chk("R3 R4 cleared after saturation", {24'd0, s_rdat}, 32'h00);
    @(negedge clk);
    s_rd = 0;

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule